// File: doc/BRIEF.md
# Video Word Interleaver with Sync Mapping

The block takes a 20-bit parallel video word that carries two 10-bit components and turns it into a stream of 10-bit words, one component per word. Bits [9:0] of each input word hold chroma and bits [19:10] hold luma. The chroma component leaves first and the luma component follows. The whole block runs on one clock at twice the video word rate. A word is accepted on a rising edge when `in_valid` and `in_ready` are both high. It is then presented on the output as two consecutive transfers, and each transfer completes on an edge where `out_valid` and `out_ready` are both high.

Each 10-bit component can be rewritten on its way out so that an 8-bit source still produces proper 10-bit timing-reference codes. If the eight upper bits of a component are all zero, its two low bits are forced to zero. If the eight upper bits are all one, its two low bits are forced to one. All other codes pass through unchanged. Holding the plain control input `map_off` high disables this rewrite, which is useful for non-video payloads.

Back-pressure works as follows. While `out_ready` is low, the presented word stays where it is and no new input is taken. When the last component of a word is consumed, the next input word can be accepted on the same edge. This keeps the output busy on every cycle as long as the source keeps up.

Top module: `vwi_interleave`

## Requirements
- R1: After a synchronous reset (rst high on a clock edge), out_valid is 0 and in_ready is 1.
- R2: An input word is captured on a rising edge where in_valid and in_ready are both high. out_valid is 1 in the cycle that follows.
- R3: Each captured word is emitted as two output transfers: first bits [9:0] (chroma), then bits [19:10] (luma). Then out_valid returns to 0 unless another word was captured.
- R4: While out_valid is 1 and out_ready is 0, out_word holds its value (map_off unchanged) and in_ready is 0.
- R5: On the edge that consumes the luma half, a waiting input word is captured. Its chroma half appears in the next cycle with no idle cycle in between.
- R6: With map_off low, a component whose bits [9:2] are all zero is emitted with bits [1:0] = 00 (codes 000h-003h become 000h).
- R7: With map_off low, a component whose bits [9:2] are all one is emitted with bits [1:0] = 11 (codes 3FCh-3FFh become 3FFh).
- R8: Components whose bits [9:2] are neither all zero nor all one are emitted unchanged.
- R9: With map_off high, every component is emitted unchanged. map_off acts on the word presented in the current cycle.
- R10: The two components of one input word are mapped independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the video word rate |
| rst | input | 1 | Synchronous reset, active high |
| map_off | input | 1 | High disables reserved-code mapping |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_word | input | 20 | Luma in [19:10], chroma in [9:0] |
| out_valid | output | 1 | out_word holds a component |
| out_ready | input | 1 | Downstream takes out_word this cycle |
| out_word | output | 10 | Interleaved, mapped component |

## Verification
Two operations can fall on one clock edge: the luma half of a held word is consumed, and the next input word is captured. The test provokes this by keeping in_valid high with a second word while the first word drains under a steady out_ready. It then requires an unbroken chroma-luma-chroma-luma output sequence, with in_ready low during the chroma cycle and high during the luma cycle. A second collision, a map_off change while a word is stalled, is judged by the output word switching between its mapped and raw forms within the same held transfer.

// File: rtl/vwi_pkg.sv
package vwi_pkg;
  localparam int unsigned VWI_COMP_W = 10;
  localparam int unsigned VWI_COMP_N = 2;
  localparam int unsigned VWI_TAG_W  = 2;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vwi_pace.sv
module vwi_pace #(
  parameter int unsigned COMP_N = vwi_pkg::VWI_COMP_N,
  localparam int unsigned SEL_W = vwi_pkg::sel_width(COMP_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             load,
  output logic [SEL_W-1:0] sel
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(COMP_N - 1);

  logic full;
  logic fire;
  logic at_last;

  assign at_last   = (sel == LAST);
  assign fire      = full && out_ready;
  assign in_ready  = !full || (fire && at_last);
  assign load      = in_valid && in_ready;
  assign out_valid = full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      sel  <= '0;
    end else if (load) begin
      full <= 1'b1;
      sel  <= '0;
    end else if (fire) begin
      if (at_last) begin
        full <= 1'b0;
        sel  <= '0;
      end else begin
        sel <= sel + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vwi_hold.sv
module vwi_hold #(
  parameter int unsigned WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/vwi_code_map.sv
module vwi_code_map #(
  parameter int unsigned COMP_W = vwi_pkg::VWI_COMP_W,
  parameter int unsigned TAG_W  = vwi_pkg::VWI_TAG_W
) (
  input  logic              bypass,
  input  logic [COMP_W-1:0] din,
  output logic [COMP_W-1:0] dout
);
  localparam int unsigned HEAD_W = COMP_W - TAG_W;

  logic [HEAD_W-1:0] head;
  logic all_lo;
  logic all_hi;

  assign head   = din[COMP_W-1:TAG_W];
  assign all_lo = ~|head;
  assign all_hi = &head;

  always_comb begin
    if (bypass)      dout = din;
    else if (all_lo) dout = {head, {TAG_W{1'b0}}};
    else if (all_hi) dout = {head, {TAG_W{1'b1}}};
    else             dout = din;
  end
endmodule

// File: rtl/vwi_interleave.sv
module vwi_interleave #(
  parameter int unsigned COMP_W = vwi_pkg::VWI_COMP_W,
  parameter int unsigned COMP_N = vwi_pkg::VWI_COMP_N,
  parameter int unsigned TAG_W  = vwi_pkg::VWI_TAG_W,
  localparam int unsigned WORD_W = COMP_W * COMP_N,
  localparam int unsigned SEL_W  = vwi_pkg::sel_width(COMP_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_off,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COMP_W-1:0] out_word
);
  logic              load;
  logic [SEL_W-1:0]  sel;
  logic [WORD_W-1:0] held;
  logic [COMP_W-1:0] mapped [COMP_N];

  vwi_pace #(.COMP_N(COMP_N)) u_pace (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .load(load), .sel(sel)
  );

  vwi_hold #(.WIDTH(WORD_W)) u_hold (
    .clk(clk), .rst(rst), .load(load), .d(in_word), .q(held)
  );

  for (genvar g = 0; g < COMP_N; g++) begin : g_lane
    vwi_code_map #(.COMP_W(COMP_W), .TAG_W(TAG_W)) u_map (
      .bypass(map_off), .din(held[g*COMP_W +: COMP_W]), .dout(mapped[g])
    );
  end

  assign out_word = mapped[sel];
endmodule

// File: rtl/vwi_interleave_chk.sv
module vwi_interleave_chk #(
  parameter int unsigned COMP_W = 10,
  parameter int unsigned TAG_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              map_off,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [COMP_W-1:0] out_word
);
  p_capture_valid_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  p_stall_stable_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && (map_off != $past(map_off) || $stable(out_word)));

  p_stall_no_take_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  p_low_code_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !map_off && (out_word[COMP_W-1:TAG_W] == '0) |-> out_word[TAG_W-1:0] == '0);

  p_high_code_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !map_off && (&out_word[COMP_W-1:TAG_W]) |-> (&out_word[TAG_W-1:0]));
endmodule

bind vwi_interleave vwi_interleave_chk #(.COMP_W(COMP_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/test_vwi_interleave.sv
module test_vwi_interleave;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       map_off = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [19:0] in_word = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [9:0] out_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vwi_interleave i_vwi_interleave (
    .clk(clk), .rst(rst), .map_off(map_off), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  // [40:21] input word, [20] map_off, [19:10] expected chroma, [9:0] expected luma
  localparam int NV = 8;
  localparam logic [40:0] VEC [NV] = '{
    {{10'h001, 10'h3FD}, 1'b0, 10'h3FF, 10'h000},  // R6 R7 R10
    {{10'h200, 10'h0FF}, 1'b0, 10'h0FF, 10'h200},  // R8
    {{10'h001, 10'h3FD}, 1'b1, 10'h3FD, 10'h001},  // R9
    {{10'h3FC, 10'h003}, 1'b0, 10'h000, 10'h3FF},  // R6 R7
    {{10'h004, 10'h3FB}, 1'b0, 10'h3FB, 10'h004},  // R8 edges
    {{10'h000, 10'h3FF}, 1'b0, 10'h3FF, 10'h000},  // R6 R7 exact
    {{10'h2AA, 10'h002}, 1'b0, 10'h000, 10'h2AA},  // R10
    {{10'h3FE, 10'h155}, 1'b1, 10'h155, 10'h3FE}   // R9
  };

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid", 20'(out_valid), 20'd0);
    chk("R1 in_ready", 20'(in_ready), 20'd1);

    // table walk, R2 R3 and mapping
    out_ready = 1'b1;
    for (int i = 0; i < NV; i++) begin
      in_word  = VEC[i][40:21];
      map_off  = VEC[i][20];
      in_valid = 1'b1;
      chk("R2 ready", 20'(in_ready), 20'd1);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 valid", 20'(out_valid), 20'd1);
      chk("R3 chroma", 20'(out_word), 20'(VEC[i][19:10]));
      @(negedge clk);
      chk("R3 luma", 20'(out_word), 20'(VEC[i][9:0]));
      @(negedge clk);
      chk("R3 drained", 20'(out_valid), 20'd0);
    end

    // R4 back-pressure
    map_off = 1'b0;
    out_ready = 1'b0;
    in_word = {10'h155, 10'h3FE};
    in_valid = 1'b1;
    @(negedge clk);
    in_word = 20'hABCDE;
    for (int k = 0; k < 3; k++) begin
      chk("R4 held", 20'(out_word), 20'h3FF);
      chk("R4 no ready", 20'(in_ready), 20'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R4 luma after stall", 20'(out_word), 20'h155);
    @(negedge clk);
    chk("R4 drained", 20'(out_valid), 20'd0);

    // R5 same-edge handoff
    in_word = {10'h3FD, 10'h002};
    in_valid = 1'b1;
    @(negedge clk);
    chk("R5 chroma A", 20'(out_word), 20'h000);
    chk("R5 ready low on chroma", 20'(in_ready), 20'd0);
    in_word = {10'h123, 10'h3FC};
    @(negedge clk);
    chk("R5 luma A", 20'(out_word), 20'h3FF);
    chk("R5 ready high on luma", 20'(in_ready), 20'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 chroma B valid", 20'(out_valid), 20'd1);
    chk("R5 chroma B", 20'(out_word), 20'h3FF);
    @(negedge clk);
    chk("R5 luma B", 20'(out_word), 20'h123);
    @(negedge clk);
    chk("R5 drained", 20'(out_valid), 20'd0);

    // R9 map_off change while stalled
    out_ready = 1'b0;
    in_word = {10'h001, 10'h002};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 mapped", 20'(out_word), 20'h000);
    map_off = 1'b1;
    #1;
    chk("R9 raw", 20'(out_word), 20'h002);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 raw luma", 20'(out_word), 20'h001);
    @(negedge clk);

    // R1 reset while holding a word
    out_ready = 1'b0;
    map_off = 1'b0;
    in_word = 20'h12345;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 valid after reset", 20'(out_valid), 20'd0);
    chk("R1 ready after reset", 20'(in_ready), 20'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule